// File: doc/BRIEF.md
# Virtually indexed, physically tagged cache lookup

This unit is the read-side lookup of a 16 KB data cache. The cache is organised as 128 sets of four 32-byte lines. Every bit that picks a set or a word lies inside the untranslated page offset, so the unit starts reading the set as soon as a lookup arrives with that offset. Address translation runs in parallel. The 20-bit physical tag arrives one cycle later, and the unit compares it against the four stored tags. A hit returns the selected 32-bit word. A miss raises a request, carrying the full physical address, toward the next memory level.

The line comes back later on a one-beat fill port. The fill carries the set number, the physical tag and the whole 256-bit line. The unit picks the way to replace by itself. It uses a per-set tree pseudo-LRU, and an empty way always goes first. The environment does not issue a fill in the same cycle as a lookup to that set, and does not issue one while such a lookup is between its two stages. It never fills a tag that is already present in the set.

Top module: `vipt_dcache_lookup`

## Requirements
- R1: A synchronous active-low reset clears every valid bit, the replacement state and both pipeline stages. After reset, `rsp_valid` and `mreq_valid` are 0, and the first lookup to any set misses.
- R2: A lookup sampled with `lk_valid`=1 at clock edge k has its physical tag sampled on `lk_ptag` at edge k+1. Its result is shown with `rsp_valid`=1 for exactly the one cycle that follows edge k+1. `rsp_valid` is 0 in every other cycle.
- R3: The set is `lk_vpage_off[11:5]` and the word within the line is `lk_vpage_off[4:2]`. Bits [1:0] have no effect on the word returned. Sets are independent of one another.
- R4: A lookup hits only when a valid way of its set holds a tag equal to `lk_ptag`. On a hit, `rsp_hit`=1 and `rsp_word` is bits [32*w+31 : 32*w] of that way's line, where w is the word number.
- R5: On a miss, `rsp_hit`=0 and `mreq_valid`=1 in the response cycle. `mreq_addr` is {`lk_ptag`, `lk_vpage_off`}.
- R6: A fill sampled at an edge writes `fill_line`, the tag `fill_ptag` and a set valid bit into one way of set `fill_set`. Lookups sampled at later edges see the new line.
- R7: If the filled set has an invalid way, the lowest-numbered invalid way is the one replaced.
- R8: When all four ways are valid, the victim comes from three tree bits per set, all 0 after reset. The root bit picks the half: 0 means ways 0/1 and 1 means ways 2/3. The left leaf picks way 0 or 1, and the right leaf picks way 2 or 3. Every hit and every fill to a way sets the root and that way's leaf to point at the other side.
- R9: At most one way matches in any lookup.
- R10: Without a response, `rsp_hit`, `rsp_word`, `mreq_valid` and `mreq_addr` are all 0. `rsp_word` is 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request, stage 1 |
| lk_vpage_off | input | 12 | Page-offset bits of the virtual address |
| lk_ptag | input | 20 | Physical tag, presented one cycle after the lookup |
| rsp_valid | output | 1 | Result of the lookup is shown |
| rsp_hit | output | 1 | The lookup hit |
| rsp_word | output | 32 | Word read on a hit |
| mreq_valid | output | 1 | Miss request to the next level |
| mreq_addr | output | 32 | Physical address of the missing access |
| fill_valid | input | 1 | Refill beat |
| fill_set | input | 7 | Set being refilled |
| fill_ptag | input | 20 | Physical tag of the refilled line |
| fill_line | input | 256 | Complete line data |

## Verification
A wrong valid bit or stored tag shows in the response cycle of the next lookup to that set. It appears two edges after the lookup is issued, as a hit that should be a miss, or the other way round, together with a missing or spurious `mreq_valid`. A wrong tree bit or a wrong victim choice shows only later. It becomes visible when a lookup misses on a line that should have stayed, or hits a line that should have been replaced. That needs a full set plus one more fill. A line written into the wrong place shows as a wrong `rsp_word` on the first hit to it. The bench therefore keeps its own per-set model of tags, line contents and tree bits, and compares all outputs on every clock.

// File: rtl/vipt_cache_pkg.sv
// Package: shared geometry of the lookup unit.
// Assumes the set index plus the line offset fit in the page offset,
// so the set can be read before translation is finished.
package vipt_cache_pkg;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 32;
    localparam int WORD_BYTES = 4;
    localparam int NUM_SETS   = 128;
    localparam int NUM_WAYS   = 4;   // the tree replacement is built for four ways

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(NUM_SETS);
    localparam int SPAN_W  = IDX_W + OFF_W;           // bits taken from the page offset
    localparam int TAG_W   = ADDR_W - SPAN_W;
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int WORD_W  = WORD_BYTES * 8;
    localparam int BSEL_W  = $clog2(WORD_BYTES);
    localparam int WSEL_W  = OFF_W - BSEL_W;
    localparam int WAY_W   = $clog2(NUM_WAYS);
    localparam int TREE_W  = NUM_WAYS - 1;
endpackage

// File: rtl/vc_tag_store.sv
// Module: tag and valid storage of all sets.
// Reads one whole set into registers when a lookup is accepted.
// Writes one way on a fill. Valid bits clear on reset; tags do not.
// Assumes the environment never reads and fills the same set in one cycle.
module vc_tag_store #(
    parameter int SETS     = 128,
    parameter int WAYS     = 4,
    parameter int TAG_BITS = 20,
    localparam int IDX_BITS = $clog2(SETS),
    localparam int WAY_BITS = $clog2(WAYS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [IDX_BITS-1:0]            rd_idx,
    input  logic                           wr_en,
    input  logic [IDX_BITS-1:0]            wr_idx,
    input  logic [WAY_BITS-1:0]            wr_way,
    input  logic [TAG_BITS-1:0]            wr_tag,
    output logic [WAYS-1:0][TAG_BITS-1:0]  rd_tags,
    output logic [WAYS-1:0]                rd_vld,
    output logic [WAYS-1:0]                wr_set_vld
);
    logic [WAYS-1:0][TAG_BITS-1:0] tag_mem [SETS];
    logic [WAYS-1:0]               vld_mem [SETS];

    // Valid-bit state of the set being filled, for victim choice
    assign wr_set_vld = vld_mem[wr_idx];

    // Valid bits: cleared on reset, set by a fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
        end else if (wr_en) begin
            vld_mem[wr_idx][wr_way] <= 1'b1;
        end
    end

    // Tag array write on fill
    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_idx][wr_way] <= wr_tag;
    end

    // Stage-1 read of the indexed set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= '0;
            rd_tags <= '0;
        end else if (rd_en) begin
            rd_vld  <= vld_mem[rd_idx];
            rd_tags <= tag_mem[rd_idx];
        end
    end

    // R6: a fill leaves the written way valid
    a_r6_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_mem[$past(wr_idx)][$past(wr_way)]);
endmodule

// File: rtl/vc_data_store.sv
// Module: line data storage.
// A fill writes one whole line per beat. A lookup reads the selected word of
// every way of the set into registers; the tag compare picks one of them later.
module vc_data_store #(
    parameter int SETS      = 128,
    parameter int WAYS      = 4,
    parameter int LINE_BITS = 256,
    parameter int WORD_BITS = 32,
    localparam int IDX_BITS  = $clog2(SETS),
    localparam int WAY_BITS  = $clog2(WAYS),
    localparam int WSEL_BITS = $clog2(LINE_BITS / WORD_BITS)
) (
    input  logic                            clk,
    input  logic                            rd_en,
    input  logic [IDX_BITS-1:0]             rd_idx,
    input  logic [WSEL_BITS-1:0]            rd_wsel,
    input  logic                            wr_en,
    input  logic [IDX_BITS-1:0]             wr_idx,
    input  logic [WAY_BITS-1:0]             wr_way,
    input  logic [LINE_BITS-1:0]            wr_line,
    output logic [WAYS-1:0][WORD_BITS-1:0]  rd_words
);
    logic [LINE_BITS-1:0] line_mem [SETS*WAYS];

    // Line write on fill
    always_ff @(posedge clk) begin
        if (wr_en) line_mem[{wr_idx, wr_way}] <= wr_line;
    end

    // Stage-1 word read from each way of the set
    always_ff @(posedge clk) begin
        if (rd_en) begin
            for (int w = 0; w < WAYS; w++)
                rd_words[w] <= line_mem[{rd_idx, WAY_BITS'(w)}][rd_wsel*WORD_BITS +: WORD_BITS];
        end
    end
endmodule

// File: rtl/vc_plru.sv
// Module: tree pseudo-LRU replacement state, three bits per set, four ways.
// Bit 0 is the root (0 = ways 0/1 next), bit 1 the left leaf (0 = way 0),
// bit 2 the right leaf (0 = way 2). Hits and fills point the tree away from
// the used way. An invalid way, lowest first, always wins over the tree.
module vc_plru #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int IDX_BITS  = $clog2(SETS),
    localparam int WAY_BITS  = $clog2(WAYS),
    localparam int TREE_BITS = WAYS - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                touch_en,
    input  logic [IDX_BITS-1:0] touch_idx,
    input  logic [WAY_BITS-1:0] touch_way,
    input  logic                fill_en,
    input  logic [IDX_BITS-1:0] fill_idx,
    input  logic [WAYS-1:0]     fill_set_vld,
    output logic [WAY_BITS-1:0] victim_way
);
    logic [TREE_BITS-1:0] tree_mem [SETS];
    logic [WAY_BITS-1:0]  tree_pick;

    // Way the tree bits point at
    function automatic logic [WAY_BITS-1:0] pick_of(input logic [TREE_BITS-1:0] t);
        if (t[0]) return t[2] ? WAY_BITS'(3) : WAY_BITS'(2);
        else      return t[1] ? WAY_BITS'(1) : WAY_BITS'(0);
    endfunction

    // Tree bits after using a way
    function automatic logic [TREE_BITS-1:0] away_from(input logic [TREE_BITS-1:0] t,
                                                       input logic [WAY_BITS-1:0]  way);
        case (way)
            2'd0:    return {t[2], 1'b1, 1'b1};
            2'd1:    return {t[2], 1'b0, 1'b1};
            2'd2:    return {1'b1, t[1], 1'b0};
            default: return {1'b0, t[1], 1'b0};
        endcase
    endfunction

    // Victim: lowest invalid way, else the tree's choice
    always_comb begin
        tree_pick  = pick_of(tree_mem[fill_idx]);
        victim_way = tree_pick;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!fill_set_vld[w]) victim_way = WAY_BITS'(w);
    end

    // Tree update on hit and on fill; the fill wins on a shared set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_mem[s] <= '0;
        end else begin
            if (touch_en) tree_mem[touch_idx] <= away_from(tree_mem[touch_idx], touch_way);
            if (fill_en)  tree_mem[fill_idx]  <= away_from(tree_mem[fill_idx], victim_way);
        end
    end

    // R7: with an empty way present, an occupied way is never replaced
    a_r7_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(&fill_set_vld)) |-> !fill_set_vld[victim_way]);

    // R8: right after a fill the tree no longer points at the filled way
    a_r8_fill_moves_away: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (pick_of(tree_mem[$past(fill_idx)]) != $past(victim_way)));
endmodule

// File: rtl/vipt_dcache_lookup.sv
// Module: two-stage read lookup of a virtually indexed, physically tagged cache.
// Stage 1 reads tags, valid bits and the addressed word of every way, using
// only page-offset bits. Stage 2 compares against the physical tag, which
// arrives one cycle after the lookup, and registers hit data or a miss request.
// Assumes fills never collide with a lookup to the same set in flight.
module vipt_dcache_lookup
    import vipt_cache_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [SPAN_W-1:0]  lk_vpage_off,
    input  logic [TAG_W-1:0]   lk_ptag,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [WORD_W-1:0]  rsp_word,
    output logic               mreq_valid,
    output logic [ADDR_W-1:0]  mreq_addr,
    input  logic               fill_valid,
    input  logic [IDX_W-1:0]   fill_set,
    input  logic [TAG_W-1:0]   fill_ptag,
    input  logic [LINE_W-1:0]  fill_line
);
    logic                             s1_valid;
    logic [IDX_W-1:0]                 s1_idx;
    logic [OFF_W-1:0]                 s1_off;
    logic [NUM_WAYS-1:0][TAG_W-1:0]   s1_tags;
    logic [NUM_WAYS-1:0]              s1_vld;
    logic [NUM_WAYS-1:0][WORD_W-1:0]  s1_words;
    logic [NUM_WAYS-1:0]              fill_set_vld;
    logic [WAY_W-1:0]                 victim_way;
    logic [NUM_WAYS-1:0]              hit_vec;
    logic                             any_hit;
    logic [WAY_W-1:0]                 hit_way;
    logic [WORD_W-1:0]                hit_word;
    logic [IDX_W-1:0]                 lk_idx;
    logic [WSEL_W-1:0]                lk_wsel;

    assign lk_idx  = lk_vpage_off[SPAN_W-1:OFF_W];
    assign lk_wsel = lk_vpage_off[OFF_W-1:BSEL_W];

    vc_tag_store #(.SETS(NUM_SETS), .WAYS(NUM_WAYS), .TAG_BITS(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (lk_valid),
        .rd_idx     (lk_idx),
        .wr_en      (fill_valid),
        .wr_idx     (fill_set),
        .wr_way     (victim_way),
        .wr_tag     (fill_ptag),
        .rd_tags    (s1_tags),
        .rd_vld     (s1_vld),
        .wr_set_vld (fill_set_vld)
    );

    vc_data_store #(.SETS(NUM_SETS), .WAYS(NUM_WAYS), .LINE_BITS(LINE_W), .WORD_BITS(WORD_W)) u_data (
        .clk      (clk),
        .rd_en    (lk_valid),
        .rd_idx   (lk_idx),
        .rd_wsel  (lk_wsel),
        .wr_en    (fill_valid),
        .wr_idx   (fill_set),
        .wr_way   (victim_way),
        .wr_line  (fill_line),
        .rd_words (s1_words)
    );

    vc_plru #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) u_plru (
        .clk          (clk),
        .rst_n        (rst_n),
        .touch_en     (s1_valid && any_hit),
        .touch_idx    (s1_idx),
        .touch_way    (hit_way),
        .fill_en      (fill_valid),
        .fill_idx     (fill_set),
        .fill_set_vld (fill_set_vld),
        .victim_way   (victim_way)
    );

    // Stage-1 control: remember which set and byte the lookup wanted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_idx   <= '0;
            s1_off   <= '0;
        end else begin
            s1_valid <= lk_valid;
            if (lk_valid) begin
                s1_idx <= lk_idx;
                s1_off <= lk_vpage_off[OFF_W-1:0];
            end
        end
    end

    // Per-way physical tag compare
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign hit_vec[w] = s1_vld[w] && (s1_tags[w] == lk_ptag);
    end

    // Hit way encode and word select
    always_comb begin
        hit_way  = '0;
        hit_word = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way  = WAY_W'(w);
                hit_word = hit_word | s1_words[w];
            end
        end
    end
    assign any_hit = |hit_vec;

    // Stage-2 result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_word   <= '0;
            mreq_valid <= 1'b0;
            mreq_addr  <= '0;
        end else begin
            rsp_valid  <= s1_valid;
            rsp_hit    <= s1_valid && any_hit;
            rsp_word   <= (s1_valid && any_hit) ? hit_word : '0;
            mreq_valid <= s1_valid && !any_hit;
            mreq_addr  <= (s1_valid && !any_hit) ? {lk_ptag, s1_idx, s1_off} : '0;
        end
    end

    // R9: never more than one matching way
    a_r9_one_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $onehot0(hit_vec));

    // R2: a response follows every accepted lookup, and only those
    a_r2_rsp_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> ##1 rsp_valid);
    a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> ##1 !rsp_valid);

    // R5: a miss response always carries a miss request
    a_r5_miss_request: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> mreq_valid);

    // R10: outputs quiet when no response is shown
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !mreq_valid && rsp_word == '0 && mreq_addr == '0));
endmodule

// File: tb/tb_vipt_dcache_lookup.sv
`timescale 1ns/1ps
module tb_vipt_dcache_lookup;
    import vipt_cache_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               lk_valid = 1'b0;
    logic [SPAN_W-1:0]  lk_vpage_off = '0;
    logic [TAG_W-1:0]   lk_ptag = '0;
    logic               rsp_valid, rsp_hit, mreq_valid;
    logic [WORD_W-1:0]  rsp_word;
    logic [ADDR_W-1:0]  mreq_addr;
    logic               fill_valid = 1'b0;
    logic [IDX_W-1:0]   fill_set = '0;
    logic [TAG_W-1:0]   fill_ptag = '0;
    logic [LINE_W-1:0]  fill_line = '0;

    always #4 clk = ~clk;   // 125 MHz

    vipt_dcache_lookup dut (.*);

    int checks = 0;
    int fails  = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;

    // Reference model: contents per set and way, plus tree bits
    bit        m_vld  [NUM_SETS][NUM_WAYS];
    int        m_tag  [NUM_SETS][NUM_WAYS];
    int        m_seed [NUM_SETS][NUM_WAYS];
    bit [2:0]  m_tree [NUM_SETS];

    // Expected outputs for the current cycle
    bit          exp_rv = 0, exp_hit = 0, exp_mv = 0;
    logic [31:0] exp_word = '0, exp_maddr = '0;
    string       exp_rq = "R2";

    function automatic logic [31:0] mkword(int seed, int w);
        return 32'(seed) * 32'h9E3779B1 + 32'(w) * 32'h01010101 + 32'h5A5A0000;
    endfunction

    function automatic int model_victim(int s);
        for (int w = 0; w < NUM_WAYS; w++) if (!m_vld[s][w]) return w;
        if (m_tree[s][0] == 1'b0) return m_tree[s][1] ? 1 : 0;
        return m_tree[s][2] ? 3 : 2;
    endfunction

    function automatic void model_use(int s, int w);
        if (w < 2) begin
            m_tree[s][0] = 1'b1;
            m_tree[s][1] = (w == 0);
        end else begin
            m_tree[s][0] = 1'b0;
            m_tree[s][2] = (w == 2);
        end
    endfunction

    function automatic void model_clear();
        for (int s = 0; s < NUM_SETS; s++) begin
            m_tree[s] = 3'b000;
            for (int w = 0; w < NUM_WAYS; w++) m_vld[s][w] = 1'b0;
        end
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, act, expv, $time);
        end
    endtask

    // Compare all outputs every clock, 3 ns after the edge
    always @(posedge clk) begin
        #3;
        if (chk_en && !done) begin
            chk("R2 rsp_valid", 32'(rsp_valid), 32'(exp_rv));
            if (!exp_rv) begin
                chk("R10 idle hit",  32'(rsp_hit), 32'd0);
                chk("R10 idle mreq", 32'(mreq_valid), 32'd0);
                chk("R10 idle word", rsp_word, 32'd0);
            end else begin
                chk({exp_rq, " hit"},  32'(rsp_hit), 32'(exp_hit));
                chk({exp_rq, " word"}, rsp_word, exp_word);
                chk("R5 mreq_valid", 32'(mreq_valid), 32'(exp_mv));
                if (exp_mv) chk("R5 mreq_addr", mreq_addr, exp_maddr);
            end
        end
    end

    task automatic lookup(input int s, input int off, input int tag, input string rq);
        logic [SPAN_W-1:0] po;
        int hw;
        po = {IDX_W'(s), OFF_W'(off)};
        @(negedge clk);
        lk_valid = 1'b1; lk_vpage_off = po; lk_ptag = '0;
        @(negedge clk);
        lk_valid = 1'b0; lk_ptag = TAG_W'(tag);
        hw = -1;
        for (int w = 0; w < NUM_WAYS; w++)
            if (m_vld[s][w] && m_tag[s][w] == tag) hw = w;
        exp_rv = 1'b1; exp_rq = rq;
        exp_hit = (hw >= 0);
        exp_mv  = (hw < 0);
        exp_word  = (hw >= 0) ? mkword(m_seed[s][hw], off / WORD_BYTES) : 32'd0;
        exp_maddr = {TAG_W'(tag), po};
        if (hw >= 0) model_use(s, hw);
        @(negedge clk);
        exp_rv = 1'b0; exp_hit = 1'b0; exp_mv = 1'b0; exp_rq = "R2";
    endtask

    task automatic do_fill(input int s, input int tag, input int seed);
        int v;
        @(negedge clk);
        v = model_victim(s);
        m_vld[s][v] = 1'b1; m_tag[s][v] = tag; m_seed[s][v] = seed;
        model_use(s, v);
        fill_valid = 1'b1; fill_set = IDX_W'(s); fill_ptag = TAG_W'(tag);
        for (int w = 0; w < LINE_BYTES / WORD_BYTES; w++)
            fill_line[w*WORD_W +: WORD_W] = mkword(seed, w);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        chk_en = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 mreq_valid after reset", 32'(mreq_valid), 32'd0);
        chk("R1 rsp_word after reset", rsp_word, 32'd0);
        chk_en = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        model_clear();
        apply_reset();

        // R1: empty cache misses; R5: miss address
        lookup(5, 8, 'h1A2B3, "R1 first miss");
        lookup(127, 31, 'hFFFFF, "R5 miss at top set");

        // R6/R7: fills land in ways 0..3 in order
        do_fill(5, 'h1A2B3, 11);
        lookup(5, 8, 'h1A2B3, "R6 hit after fill");
        lookup(5, 9, 'h1A2B3, "R3 byte bits ignored");
        lookup(5, 11, 'h1A2B3, "R3 byte bits ignored");
        lookup(5, 28, 'h1A2B3, "R4 last word");
        lookup(5, 0, 'h00042, "R4 other tag misses");
        lookup(6, 8, 'h1A2B3, "R3 other set misses");
        do_fill(5, 'h00042, 12);
        do_fill(5, 'h00777, 13);
        do_fill(5, 'hABCDE, 14);
        lookup(5, 4, 'h00042, "R7 way1");
        lookup(5, 16, 'h00777, "R7 way2");
        lookup(5, 20, 'hABCDE, "R7 way3");
        lookup(5, 0, 'h1A2B3, "R9 single way data");

        // R8: replacement in a full set follows the tree
        do_fill(5, 'h55555, 15);
        lookup(5, 12, 'h1A2B3, "R8 after evict");
        lookup(5, 12, 'h00042, "R8 after evict");
        lookup(5, 12, 'h00777, "R8 after evict");
        lookup(5, 12, 'hABCDE, "R8 after evict");
        lookup(5, 12, 'h55555, "R8 new line");
        lookup(5, 0, 'h00777, "R8 touch");
        do_fill(5, 'h66666, 16);
        do_fill(5, 'h77777, 17);
        for (int t = 0; t < 6; t++)
            lookup(5, 4 * t, (t == 0) ? 'h1A2B3 : (t == 1) ? 'h00042 : (t == 2) ? 'h00777 :
                              (t == 3) ? 'h55555 : (t == 4) ? 'h66666 : 'h77777, "R8 survivors");

        // R3: boundary set, all-ones tag
        do_fill(127, 'hFFFFF, 21);
        lookup(127, 31, 'hFFFFF, "R3 top set hit");
        lookup(0, 0, 'hFFFFF, "R3 set 0 misses");

        // R1: reset clears valid state
        apply_reset();
        lookup(5, 8, 'h1A2B3, "R1 miss after reset");
        lookup(127, 31, 'hFFFFF, "R1 miss after reset");
        do_fill(5, 'h1A2B3, 31);
        lookup(5, 8, 'h1A2B3, "R7 way0 after reset");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule